// File: doc/BRIEF.md
# Reservation Station Pool with Broadcast Wakeup

This block holds a small number of decoded operations that are waiting in front of one class of functional unit. An operation enters through the issue port. For each of its two sources it brings either a value or the tag of the station that will produce that value. The entry then watches a shared result bus that carries a tag and a value. When the bus tag equals a source tag the entry is still waiting on, the entry copies the value and sets that source tag to zero. A source whose tag is zero is complete, so the entry keeps no separate ready bits.

When both source tags of an entry are zero, the entry can be handed to the functional unit. The dispatch port shows the lowest-index ready entry: its operation, both operand values and the entry's own station tag. When the unit grants that entry, it is no longer offered for dispatch. It stays occupied until its own tag appears on the result bus, and then it becomes free. Entry i owns station tag FIRST_TAG + i. Tag zero is reserved and never names a station. When no entry is free, the free indication goes low and the issue stage must hold its instruction.

Top module: `rs_pool`

## Requirements
- R1: After reset all entries are free: `iss_ready_o` is 1 and `dsp_valid_o` is 0.
- R2: An issue with `iss_valid_i` high while `iss_ready_o` is high fills the lowest-index free entry. `iss_ready_o` is 0 exactly when every entry is occupied. An issue offered while `iss_ready_o` is 0 is dropped and never reaches the dispatch port.
- R3: A source issued with tag 0 keeps the value given at issue. An entry issued with both tags 0 is offered on the dispatch port in the cycle after issue, with the issued operation and values.
- R4: An entry with any nonzero source tag is never offered for dispatch.
- R5: While an entry waits, a broadcast (`bc_valid_i` high) whose tag equals a nonzero source tag copies `bc_val_i` into that source and clears the tag. The entry can be offered in the next cycle.
- R6: In the cycle an entry is issued, a nonzero source tag that equals the tag on a valid broadcast takes the broadcast value at once and is stored as tag 0.
- R7: When several entries are ready, the lowest-index one is offered. `dsp_tag_o` equals FIRST_TAG plus that entry's index.
- R8: A grant (`dsp_grant_i` high while `dsp_valid_o` is high) removes the offered entry from dispatch. The entry stays occupied until a valid broadcast carries its own station tag, and it is free from the next cycle on.
- R9: A cycle with `bc_valid_i` low, or with a broadcast tag that matches no waiting source tag and no executing entry's own tag, leaves every entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| iss_valid_i | input | 1 | Issue request |
| iss_op_i | input | OP_W | Decoded operation to hold |
| iss_a_tag_i | input | TAG_W | Producer tag of source A, 0 when the value is given |
| iss_a_val_i | input | DATA_W | Value of source A |
| iss_b_tag_i | input | TAG_W | Producer tag of source B, 0 when the value is given |
| iss_b_val_i | input | DATA_W | Value of source B |
| iss_ready_o | output | 1 | At least one entry is free |
| bc_valid_i | input | 1 | Result broadcast is valid |
| bc_tag_i | input | TAG_W | Station tag of the broadcast result |
| bc_val_i | input | DATA_W | Broadcast result value |
| dsp_valid_o | output | 1 | A ready entry is offered |
| dsp_op_o | output | OP_W | Operation of the offered entry |
| dsp_a_o | output | DATA_W | Source A value of the offered entry |
| dsp_b_o | output | DATA_W | Source B value of the offered entry |
| dsp_tag_o | output | TAG_W | Station tag of the offered entry |
| dsp_grant_i | input | 1 | Functional unit accepts the offered entry |

## Verification
Several things can happen in the same cycle: an instruction issues, the result bus broadcasts a tag that one of the new instruction's sources is waiting for, and the same broadcast wakes older entries or frees an executing entry. The directed part of the bench issues an instruction whose source tag equals the tag broadcast in that cycle. It then expects the next dispatch to carry the broadcast value with no further wait. A random phase drives issue, broadcast and grant independently in every cycle, so these collisions happen often. A behavioural model of the entries predicts the free indication and the full dispatch port, and these are compared every cycle.

// File: rtl/rs_pkg.sv
package rs_pkg;

  // Life cycle of one station entry
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_EXEC = 2'd2
  } slot_state_e;

endpackage

// File: rtl/rs_pick.sv
// Lowest-index one-hot priority picker
module rs_pick #(
  parameter int N = 3
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);

  logic found;

  always_comb begin
    gnt_o = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  assign any_o = |req_i;

endmodule

// File: rtl/rs_entry.sv
// One reservation entry: holds op, two operands and their producer tags
module rs_entry
  import rs_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int OP_W     = 3,
  parameter int TAG_W    = 3,
  parameter int SELF_TAG = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [TAG_W-1:0]  a_tag_i,
  input  logic [DATA_W-1:0] a_val_i,
  input  logic [TAG_W-1:0]  b_tag_i,
  input  logic [DATA_W-1:0] b_val_i,
  input  logic              bc_valid_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_val_i,
  input  logic              grant_i,
  output logic              free_o,
  output logic              ready_o,
  output logic [OP_W-1:0]   op_o,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o
);

  slot_state_e       st_q, st_d;
  logic [OP_W-1:0]   op_q, op_d;
  logic [DATA_W-1:0] a_q, a_d, b_q, b_d;
  logic [TAG_W-1:0]  qa_q, qa_d, qb_q, qb_d;
  logic              iss_hit_a, iss_hit_b, wake_a, wake_b, own_done, pay_en;

  // tag zero never matches: a completed source is never overwritten
  assign iss_hit_a = bc_valid_i && (a_tag_i != '0) && (bc_tag_i == a_tag_i);
  assign iss_hit_b = bc_valid_i && (b_tag_i != '0) && (bc_tag_i == b_tag_i);
  assign wake_a    = bc_valid_i && (qa_q != '0) && (bc_tag_i == qa_q);
  assign wake_b    = bc_valid_i && (qb_q != '0) && (bc_tag_i == qb_q);
  assign own_done  = bc_valid_i && (bc_tag_i == TAG_W'(SELF_TAG));

  assign pay_en = ((st_q == SLOT_FREE) && alloc_i) ||
                  ((st_q == SLOT_WAIT) && (wake_a || wake_b));

  always_comb begin
    st_d = st_q;
    op_d = op_q;
    a_d  = a_q;
    b_d  = b_q;
    qa_d = qa_q;
    qb_d = qb_q;
    unique case (st_q)
      SLOT_FREE: begin
        if (alloc_i) begin
          st_d = SLOT_WAIT;
          op_d = op_i;
          a_d  = iss_hit_a ? bc_val_i : a_val_i;
          qa_d = iss_hit_a ? '0 : a_tag_i;
          b_d  = iss_hit_b ? bc_val_i : b_val_i;
          qb_d = iss_hit_b ? '0 : b_tag_i;
        end
      end
      SLOT_WAIT: begin
        if (wake_a) begin
          a_d  = bc_val_i;
          qa_d = '0;
        end
        if (wake_b) begin
          b_d  = bc_val_i;
          qb_d = '0;
        end
        if (grant_i) st_d = SLOT_EXEC;
      end
      SLOT_EXEC: begin
        if (own_done) st_d = SLOT_FREE;
      end
      default: st_d = SLOT_FREE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= SLOT_FREE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
      qa_q <= '0;
      qb_q <= '0;
    end else if (pay_en) begin
      op_q <= op_d;
      a_q  <= a_d;
      b_q  <= b_d;
      qa_q <= qa_d;
      qb_q <= qb_d;
    end
  end

  assign free_o  = (st_q == SLOT_FREE);
  assign ready_o = (st_q == SLOT_WAIT) && (qa_q == '0) && (qb_q == '0);
  assign op_o    = op_q;
  assign a_o     = a_q;
  assign b_o     = b_q;

endmodule

// File: rtl/rs_pool.sv
// Pool of reservation entries for one functional-unit class
module rs_pool #(
  parameter int ENTRIES   = 3,
  parameter int DATA_W    = 16,
  parameter int OP_W      = 3,
  parameter int TAG_W     = 3,
  parameter int FIRST_TAG = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iss_valid_i,
  input  logic [OP_W-1:0]   iss_op_i,
  input  logic [TAG_W-1:0]  iss_a_tag_i,
  input  logic [DATA_W-1:0] iss_a_val_i,
  input  logic [TAG_W-1:0]  iss_b_tag_i,
  input  logic [DATA_W-1:0] iss_b_val_i,
  output logic              iss_ready_o,
  input  logic              bc_valid_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_val_i,
  output logic              dsp_valid_o,
  output logic [OP_W-1:0]   dsp_op_o,
  output logic [DATA_W-1:0] dsp_a_o,
  output logic [DATA_W-1:0] dsp_b_o,
  output logic [TAG_W-1:0]  dsp_tag_o,
  input  logic              dsp_grant_i
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] free_v, ready_v, busy_v;
  logic [ENTRIES-1:0] alloc_pick, alloc_oh, dsp_oh, grant_oh;
  logic [OP_W-1:0]    op_arr [ENTRIES];
  logic [DATA_W-1:0]  a_arr  [ENTRIES];
  logic [DATA_W-1:0]  b_arr  [ENTRIES];
  logic [IDX_W-1:0]   dsp_idx;

  rs_pick #(.N(ENTRIES)) u_alloc_pick (
    .req_i (free_v),
    .gnt_o (alloc_pick),
    .any_o (iss_ready_o)
  );

  rs_pick #(.N(ENTRIES)) u_dsp_pick (
    .req_i (ready_v),
    .gnt_o (dsp_oh),
    .any_o (dsp_valid_o)
  );

  assign alloc_oh = alloc_pick & {ENTRIES{iss_valid_i}};
  assign grant_oh = dsp_oh & {ENTRIES{dsp_grant_i}};
  assign busy_v   = ~free_v;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    rs_entry #(
      .DATA_W   (DATA_W),
      .OP_W     (OP_W),
      .TAG_W    (TAG_W),
      .SELF_TAG (FIRST_TAG + g)
    ) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .alloc_i    (alloc_oh[g]),
      .op_i       (iss_op_i),
      .a_tag_i    (iss_a_tag_i),
      .a_val_i    (iss_a_val_i),
      .b_tag_i    (iss_b_tag_i),
      .b_val_i    (iss_b_val_i),
      .bc_valid_i (bc_valid_i),
      .bc_tag_i   (bc_tag_i),
      .bc_val_i   (bc_val_i),
      .grant_i    (grant_oh[g]),
      .free_o     (free_v[g]),
      .ready_o    (ready_v[g]),
      .op_o       (op_arr[g]),
      .a_o        (a_arr[g]),
      .b_o        (b_arr[g])
    );
  end

  // AND-OR mux driven by the one-hot dispatch pick
  always_comb begin
    dsp_op_o = '0;
    dsp_a_o  = '0;
    dsp_b_o  = '0;
    dsp_idx  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      dsp_op_o = dsp_op_o | (op_arr[i] & {OP_W{dsp_oh[i]}});
      dsp_a_o  = dsp_a_o  | (a_arr[i]  & {DATA_W{dsp_oh[i]}});
      dsp_b_o  = dsp_b_o  | (b_arr[i]  & {DATA_W{dsp_oh[i]}});
      dsp_idx  = dsp_idx  | (IDX_W'(i) & {IDX_W{dsp_oh[i]}});
    end
  end

  assign dsp_tag_o = TAG_W'(FIRST_TAG) + TAG_W'(dsp_idx);

endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
  parameter int ENTRIES = 3,
  parameter int DATA_W  = 16,
  parameter int TAG_W   = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               iss_valid_i,
  input logic               iss_ready_o,
  input logic               bc_valid_i,
  input logic               dsp_valid_o,
  input logic               dsp_grant_i,
  input logic [TAG_W-1:0]   dsp_tag_o,
  input logic [DATA_W-1:0]  dsp_a_o,
  input logic [ENTRIES-1:0] busy_v
);

  // R2: an accepted issue with no broadcast adds exactly one occupied entry
  p_alloc_adds_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_i && iss_ready_o && !bc_valid_i
      |=> $countones(busy_v) == $past($countones(busy_v)) + 1);

  // R7: without issue, broadcast or grant the offered entry stays put
  p_steady_pick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsp_valid_o && !dsp_grant_i && !bc_valid_i && !iss_valid_i
      |=> dsp_valid_o && $stable(dsp_tag_o) && $stable(dsp_a_o));

  // R8: a granted entry is not offered again in the next cycle
  p_grant_retires_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsp_valid_o && dsp_grant_i
      |=> !(dsp_valid_o && dsp_tag_o == $past(dsp_tag_o)));

  // R9: entries are only released by a broadcast
  p_no_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bc_valid_i |=> $countones(busy_v) >= $past($countones(busy_v)));

endmodule

bind rs_pool rs_pool_chk #(
  .ENTRIES (ENTRIES),
  .DATA_W  (DATA_W),
  .TAG_W   (TAG_W)
) u_rs_pool_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .iss_valid_i (iss_valid_i),
  .iss_ready_o (iss_ready_o),
  .bc_valid_i  (bc_valid_i),
  .dsp_valid_o (dsp_valid_o),
  .dsp_grant_i (dsp_grant_i),
  .dsp_tag_o   (dsp_tag_o),
  .dsp_a_o     (dsp_a_o),
  .busy_v      (busy_v)
);

// File: tb/rs_pool_tb_top.sv
module rs_pool_tb_top;

  localparam int N  = 3;
  localparam int DW = 16;
  localparam int OW = 3;
  localparam int TW = 3;
  localparam int FT = 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          iss_valid;
  logic [OW-1:0] iss_op;
  logic [TW-1:0] iss_a_tag, iss_b_tag;
  logic [DW-1:0] iss_a_val, iss_b_val;
  logic          iss_ready;
  logic          bc_valid;
  logic [TW-1:0] bc_tag;
  logic [DW-1:0] bc_val;
  logic          dsp_valid;
  logic [OW-1:0] dsp_op;
  logic [DW-1:0] dsp_a, dsp_b;
  logic [TW-1:0] dsp_tag;
  logic          dsp_grant;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  rs_pool #(.ENTRIES(N), .DATA_W(DW), .OP_W(OW), .TAG_W(TW), .FIRST_TAG(FT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .iss_valid_i(iss_valid), .iss_op_i(iss_op),
    .iss_a_tag_i(iss_a_tag), .iss_a_val_i(iss_a_val),
    .iss_b_tag_i(iss_b_tag), .iss_b_val_i(iss_b_val),
    .iss_ready_o(iss_ready),
    .bc_valid_i(bc_valid), .bc_tag_i(bc_tag), .bc_val_i(bc_val),
    .dsp_valid_o(dsp_valid), .dsp_op_o(dsp_op), .dsp_a_o(dsp_a),
    .dsp_b_o(dsp_b), .dsp_tag_o(dsp_tag), .dsp_grant_i(dsp_grant)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int            m_st [N];   // 0 free, 1 waiting, 2 executing
  logic [OW-1:0] m_op [N];
  logic [DW-1:0] m_a  [N];
  logic [DW-1:0] m_b  [N];
  logic [TW-1:0] m_qa [N];
  logic [TW-1:0] m_qb [N];

  function automatic int m_free();
    for (int i = 0; i < N; i++) if (m_st[i] == 0) return i;
    return -1;
  endfunction

  function automatic int m_ready();
    for (int i = 0; i < N; i++)
      if (m_st[i] == 1 && m_qa[i] == 0 && m_qb[i] == 0) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_st[i] = 0;
    end else begin
      int af;
      int rd;
      af = m_free();
      rd = m_ready();
      for (int i = 0; i < N; i++) begin
        if (m_st[i] == 0) begin
          if (iss_valid && i == af) begin
            m_st[i] = 1;
            m_op[i] = iss_op;
            if (bc_valid && iss_a_tag != 0 && bc_tag == iss_a_tag) begin
              m_a[i] = bc_val; m_qa[i] = 0;
            end else begin
              m_a[i] = iss_a_val; m_qa[i] = iss_a_tag;
            end
            if (bc_valid && iss_b_tag != 0 && bc_tag == iss_b_tag) begin
              m_b[i] = bc_val; m_qb[i] = 0;
            end else begin
              m_b[i] = iss_b_val; m_qb[i] = iss_b_tag;
            end
          end
        end else if (m_st[i] == 1) begin
          if (bc_valid && m_qa[i] != 0 && bc_tag == m_qa[i]) begin
            m_a[i] = bc_val; m_qa[i] = 0;
          end
          if (bc_valid && m_qb[i] != 0 && bc_tag == m_qb[i]) begin
            m_b[i] = bc_val; m_qb[i] = 0;
          end
          if (dsp_grant && i == rd) m_st[i] = 2;
        end else begin
          if (bc_valid && bc_tag == TW'(FT + i)) m_st[i] = 0;
        end
      end
    end
  end

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      int rd;
      rd = m_ready();
      chk("R2 model free indication", iss_ready, (m_free() >= 0));
      chk("R4 model dispatch valid", dsp_valid, (rd >= 0));
      if (rd >= 0 && dsp_valid) begin
        chk("R7 model dispatch tag", dsp_tag, FT + rd);
        chk("R3 model dispatch op", dsp_op, m_op[rd]);
        chk("R5 model operand A", dsp_a, m_a[rd]);
        chk("R5 model operand B", dsp_b, m_b[rd]);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic clear_in();
    iss_valid = 1'b0; bc_valid = 1'b0; dsp_grant = 1'b0;
  endtask

  task automatic issue(input int op, input int at, input int av, input int bt, input int bv);
    iss_valid = 1'b1;
    iss_op    = OW'(op);
    iss_a_tag = TW'(at); iss_a_val = DW'(av);
    iss_b_tag = TW'(bt); iss_b_val = DW'(bv);
  endtask

  task automatic bcast(input int t, input int v);
    bc_valid = 1'b1; bc_tag = TW'(t); bc_val = DW'(v);
  endtask

  task automatic tick();
    @(negedge clk);
    clear_in();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    clear_in();
    iss_op = '0; iss_a_tag = '0; iss_b_tag = '0; iss_a_val = '0; iss_b_val = '0;
    bc_tag = '0; bc_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 free after reset", iss_ready, 1);
    chk("R1 no dispatch after reset", dsp_valid, 0);

    // R3: both sources given at issue
    issue(2, 0, 'h11, 0, 'h22); tick();
    chk("R3 dispatch valid", dsp_valid, 1);
    chk("R3 dispatch tag", dsp_tag, 1);
    chk("R3 dispatch A", dsp_a, 'h11);
    chk("R3 dispatch B", dsp_b, 'h22);
    chk("R3 dispatch op", dsp_op, 2);

    // fill the pool with two waiting entries
    issue(3, 5, 0, 0, 'h33); tick();
    issue(4, 0, 'h1, 6, 0); tick();
    chk("R2 full pool stalls issue", iss_ready, 0);
    chk("R7 lowest entry still offered", dsp_tag, 1);

    // R2: issue while full is dropped
    issue(7, 0, 'h77, 0, 'h78); tick();
    chk("R2 still full after dropped issue", iss_ready, 0);

    // R8 / R4: grant entry 0, waiting entries are not offered
    dsp_grant = 1'b1; tick();
    chk("R4 waiting entries not offered", dsp_valid, 0);
    chk("R8 executing entry still occupies", iss_ready, 0);

    // R9: unmatched broadcast changes nothing
    bcast(7, 'h99); tick();
    chk("R9 unmatched broadcast", dsp_valid, 0);
    chk("R9 pool still full", iss_ready, 0);

    // R5: wake entry 2 source B
    bcast(6, 'h66); tick();
    chk("R5 woken entry offered", dsp_valid, 1);
    chk("R5 woken entry tag", dsp_tag, 3);
    chk("R5 captured B", dsp_b, 'h66);
    chk("R5 kept A", dsp_a, 'h1);

    // R7: entry 1 wakes, lower index wins
    bcast(5, 'h55); tick();
    chk("R7 lower index wins", dsp_tag, 2);
    chk("R7 captured A", dsp_a, 'h55);
    chk("R7 kept B", dsp_b, 'h33);

    // R8: own-tag broadcast frees executing entry 0
    bcast(1, 'h0); tick();
    chk("R8 entry freed on own tag", iss_ready, 1);
    chk("R2 dropped issue never appears", dsp_tag, 2);

    // R6: issue and matching broadcast in the same cycle
    issue(5, 4, 0, 0, 'h7);
    bcast(4, 'h44); tick();
    chk("R6 same-cycle capture valid", dsp_valid, 1);
    chk("R6 same-cycle capture tag", dsp_tag, 1);
    chk("R6 same-cycle capture A", dsp_a, 'h44);
    chk("R6 same-cycle capture B", dsp_b, 'h7);
    chk("R6 same-cycle capture op", dsp_op, 5);

    // random phase: issue, broadcast and grant collide freely
    for (int k = 0; k < 4000; k++) begin
      iss_valid = 1'($urandom % 2);
      iss_op    = OW'($urandom);
      iss_a_tag = ($urandom % 3 == 0) ? TW'($urandom) : '0;
      iss_b_tag = ($urandom % 3 == 0) ? TW'($urandom) : '0;
      iss_a_val = DW'($urandom);
      iss_b_val = DW'($urandom);
      bc_valid  = 1'($urandom % 2);
      bc_tag    = TW'($urandom);
      bc_val    = DW'($urandom);
      dsp_grant = 1'($urandom % 2);
      @(negedge clk);
    end
    clear_in();
    @(negedge clk);

    finish_run();
  end

endmodule